// File: doc/BRIEF.md
# Fuse Word Controller with Shadow Mirror

This block fronts a one-time-programmable array of 128 words of 32 bits (16 banks of 8 words) behind a small register-bus slave. Software reads the array through a read-only window of shadow registers, not the fuses directly. The shadow window is refreshed in two cases: once on its own after reset, and again whenever software asks for a reload. The fuse array is modelled as registers. A program operation can only turn bits on, so a fuse bit that is 1 stays 1.

To burn a word, software writes the word number and a 16-bit unlock key into the control register, then writes the value into the data register. The controller then runs a timed sequence: a relax phase, a program strobe, and a second relax phase. The phase lengths come from a timing register that software sets in clock cycles. During a program or reload a busy flag is held high. Any misuse sets a sticky error flag, which software clears through a clear alias.

Bus reads return data one cycle after the address is presented. Each write strobe is acknowledged by a ready pulse on the next cycle.

Top module: `otp_shadow_ctrl`

## Requirements
- R1: After reset the shadows load on their own. Busy stays high for 128*(read strobe + 1) cycles using the reset timing (read strobe 1, relax 1, program strobe 9). After that, the control register reads all zero and the timing register reads 0x0001_1009.
- R2: Control register at 0x00: word address [6:0], busy [8] (read-only), error [9], reload command [10], key [31:16]. A write at 0x00 loads the address and key. A write at 0x04 ORs 1 bits into the address, key and reload fields.
- R3: Timing register at 0x10: program strobe [11:0], relax [15:12], read strobe [21:16]. It reads back what was written.
- R4: A write to the data register at 0x20 while idle, with key 0x3E77, programs the addressed word. Busy is then high for exactly 2*(relax+1) + (program strobe+1) cycles.
- R5: Programming ORs the data into the fuse word. A bit that is already 1 never returns to 0.
- R6: When a program operation ends, the key field reads 0 and the address field is kept.
- R7: A data-register write with a wrong key, or while busy, programs nothing and sets the error flag. Writing 1 to bit 9 at 0x08 clears the error flag.
- R8: Setting the reload bit while idle holds busy for 128*(read strobe+1) cycles. During that time the reload bit reads 1; it clears itself at the end. Shadows then equal the fuses. Programming alone leaves the shadows unchanged.
- R9: Shadow word n reads at 0x400 + 16*n for n = 0..127. Unaligned and out-of-range addresses read 0.
- R10: While busy, writes to the address, key, reload and timing fields are ignored.
- R11: Ready is high in the cycle after each write strobe. Read data reflects the address presented one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Registered read data |
| bus_ready | output | 1 | Write acknowledge, one cycle after the strobe |

## Verification
The program path is exercised with four key and state patterns: a correct key while idle, a wrong key, a correct key while a reload is running, and a second burn over an already programmed word. Between them, these separate the key check, the busy interlock and the OR rule from a plain overwrite. The shadow window is read before and after reloads, at the first and last word, and at misaligned and out-of-range offsets. This shows that only a reload moves fuse data into the shadows, and that the index decode is correct at both ends. Busy is counted cycle by cycle for program, reload and the automatic post-reset load, so that the lengths of the relax, strobe and per-word phases are each pinned down.

// File: rtl/otp_pkg.sv
package otp_pkg;
  localparam int unsigned BUS_DW     = 32;
  localparam int unsigned WADDR_FW   = 7;
  localparam logic [15:0] UNLOCK_KEY = 16'h3E77;
  localparam int unsigned BIT_BUSY   = 8;
  localparam int unsigned BIT_ERR    = 9;
  localparam int unsigned BIT_RELOAD = 10;
  localparam int unsigned KEY_LSB    = 16;

  localparam int unsigned REG_CTRL     = 'h000;
  localparam int unsigned REG_CTRL_SET = 'h004;
  localparam int unsigned REG_CTRL_CLR = 'h008;
  localparam int unsigned REG_TIMING   = 'h010;
  localparam int unsigned REG_DATA     = 'h020;
  localparam int unsigned SHADOW_BASE  = 'h400;
  localparam int unsigned SHADOW_STEP  = 16;

  typedef struct packed {
    logic [5:0]  rd_len;
    logic [3:0]  relax;
    logic [11:0] pgm_len;
  } timing_t;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_LOAD,
    SQ_PRE,
    SQ_STRB,
    SQ_POST
  } seq_state_e;
endpackage

// File: rtl/otp_seq.sv
module otp_seq
  import otp_pkg::*;
#(
  parameter int unsigned NW    = 128,
  localparam int unsigned IDX_W = $clog2(NW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_load_i,
  input  logic             start_prog_i,
  input  timing_t          timing_i,
  output logic             busy_o,
  output logic             pgm_fire_o,
  output logic             prog_done_o,
  output logic             load_done_o,
  output logic             shadow_we_o,
  output logic [IDX_W-1:0] load_idx_o
);
  seq_state_e       state_q, state_d;
  logic [11:0]      cnt_q, cnt_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [11:0]      limit;
  logic             phase_end;
  logic             seq_en;

  always_comb begin
    limit = '0;
    unique case (state_q)
      SQ_PRE, SQ_POST: limit = {8'd0, timing_i.relax};
      SQ_STRB:         limit = timing_i.pgm_len;
      SQ_LOAD:         limit = {6'd0, timing_i.rd_len};
      default:         limit = '0;
    endcase
  end

  assign phase_end = (cnt_q == limit);

  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    idx_d       = idx_q;
    pgm_fire_o  = 1'b0;
    prog_done_o = 1'b0;
    load_done_o = 1'b0;
    shadow_we_o = 1'b0;
    unique case (state_q)
      SQ_IDLE: begin
        cnt_d = '0;
        if (start_load_i) begin
          state_d = SQ_LOAD;
          idx_d   = '0;
        end else if (start_prog_i) begin
          state_d = SQ_PRE;
        end
      end
      SQ_LOAD: begin
        if (phase_end) begin
          cnt_d       = '0;
          shadow_we_o = 1'b1;
          if (idx_q == IDX_W'(NW - 1)) begin
            load_done_o = 1'b1;
            state_d     = SQ_IDLE;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      SQ_PRE: begin
        if (phase_end) begin
          cnt_d   = '0;
          state_d = SQ_STRB;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      SQ_STRB: begin
        if (phase_end) begin
          cnt_d      = '0;
          pgm_fire_o = 1'b1;
          state_d    = SQ_POST;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      SQ_POST: begin
        if (phase_end) begin
          cnt_d       = '0;
          prog_done_o = 1'b1;
          state_d     = SQ_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  assign seq_en = (state_q != SQ_IDLE) || start_load_i || start_prog_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_LOAD;
      cnt_q   <= '0;
      idx_q   <= '0;
    end else if (seq_en) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
    end
  end

  assign busy_o     = (state_q != SQ_IDLE);
  assign load_idx_o = idx_q;

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= limit);

  // R4
  prog_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_prog_i && !start_load_i && !busy_o |=> state_q == SQ_PRE);

  // R8
  load_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_done_o |-> idx_q == IDX_W'(NW - 1));
endmodule

// File: rtl/otp_fuse_store.sv
module otp_fuse_store
  import otp_pkg::*;
#(
  parameter int unsigned NW    = 128,
  localparam int unsigned IDX_W = $clog2(NW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pgm_fire_i,
  input  logic [IDX_W-1:0]  pgm_idx_i,
  input  logic [BUS_DW-1:0] pgm_data_i,
  input  logic              shadow_we_i,
  input  logic [IDX_W-1:0]  load_idx_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [BUS_DW-1:0] rd_word_o
);
  logic [BUS_DW-1:0] shadow_arr [NW];

  for (genvar g = 0; g < NW; g++) begin : g_word
    logic [BUS_DW-1:0] fuse_r;
    logic [BUS_DW-1:0] shadow_r;
    logic              burn_en;
    logic              copy_en;

    assign burn_en = pgm_fire_i && (pgm_idx_i == IDX_W'(g));
    assign copy_en = shadow_we_i && (load_idx_i == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        fuse_r <= '0;
      end else if (burn_en) begin
        fuse_r <= fuse_r | pgm_data_i;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadow_r <= '0;
      end else if (copy_en) begin
        shadow_r <= fuse_r;
      end
    end

    assign shadow_arr[g] = shadow_r;

    // R5
    or_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      burn_en |=> (fuse_r & $past(fuse_r)) == $past(fuse_r));
  end

  assign rd_word_o = shadow_arr[rd_idx_i];
endmodule

// File: rtl/otp_regs.sv
module otp_regs
  import otp_pkg::*;
#(
  parameter int unsigned NW     = 128,
  parameter int unsigned ADDR_W = 12,
  parameter timing_t     RST_TIMING = '{rd_len: 6'd1, relax: 4'd1, pgm_len: 12'd9},
  localparam int unsigned IDX_W = $clog2(NW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  input  logic              bus_wr,
  output logic [BUS_DW-1:0] bus_rdata,
  output logic              bus_ready,
  input  logic              busy_i,
  input  logic              prog_done_i,
  input  logic              load_done_i,
  input  logic [BUS_DW-1:0] shadow_word_i,
  output logic [IDX_W-1:0]  shadow_idx_o,
  output logic              start_prog_o,
  output logic              start_load_o,
  output logic [IDX_W-1:0]  word_idx_o,
  output logic [BUS_DW-1:0] prog_data_o,
  output timing_t           timing_o
);
  localparam logic [ADDR_W:0] SPAN = (ADDR_W + 1)'(NW * SHADOW_STEP);

  logic [WADDR_FW-1:0] addr_q, addr_d;
  logic [15:0]         key_q, key_d;
  logic                reload_q, reload_d;
  logic                err_q, err_d;
  timing_t             timing_q, timing_d;
  logic [BUS_DW-1:0]   data_q;
  logic [BUS_DW-1:0]   rdata_d;
  logic                hit_ctrl, hit_set, hit_clr, hit_tim, hit_data;
  logic [ADDR_W-1:0]   win_off;
  logic                in_window;

  assign hit_ctrl = bus_wr && (bus_addr == ADDR_W'(REG_CTRL));
  assign hit_set  = bus_wr && (bus_addr == ADDR_W'(REG_CTRL_SET));
  assign hit_clr  = bus_wr && (bus_addr == ADDR_W'(REG_CTRL_CLR));
  assign hit_tim  = bus_wr && (bus_addr == ADDR_W'(REG_TIMING));
  assign hit_data = bus_wr && (bus_addr == ADDR_W'(REG_DATA));

  assign start_prog_o = hit_data && !busy_i && (key_q == UNLOCK_KEY);
  assign start_load_o = !busy_i && (hit_ctrl || hit_set) && bus_wdata[BIT_RELOAD];

  assign win_off      = bus_addr - ADDR_W'(SHADOW_BASE);
  assign in_window    = (bus_addr >= ADDR_W'(SHADOW_BASE)) && ({1'b0, win_off} < SPAN)
                        && (win_off[3:0] == 4'd0);
  assign shadow_idx_o = win_off[IDX_W+3:4];

  always_comb begin
    addr_d   = addr_q;
    key_d    = key_q;
    reload_d = reload_q;
    err_d    = err_q;
    timing_d = timing_q;
    if (!busy_i) begin
      if (hit_ctrl) begin
        addr_d = bus_wdata[WADDR_FW-1:0];
        key_d  = bus_wdata[KEY_LSB +: 16];
      end else if (hit_set) begin
        addr_d = addr_q | bus_wdata[WADDR_FW-1:0];
        key_d  = key_q | bus_wdata[KEY_LSB +: 16];
      end
      if (hit_tim) begin
        timing_d = bus_wdata[$bits(timing_t)-1:0];
      end
    end
    if (prog_done_i) begin
      key_d = '0;
    end
    if (start_load_o) begin
      reload_d = 1'b1;
    end else if (load_done_i) begin
      reload_d = 1'b0;
    end
    if (hit_data && !start_prog_o) begin
      err_d = 1'b1;
    end else if (hit_clr && bus_wdata[BIT_ERR]) begin
      err_d = 1'b0;
    end
  end

  always_comb begin
    rdata_d = '0;
    if (in_window) begin
      rdata_d = shadow_word_i;
    end else if (bus_addr == ADDR_W'(REG_CTRL)) begin
      rdata_d = {key_q, 5'd0, reload_q, err_q, busy_i, 1'b0, addr_q};
    end else if (bus_addr == ADDR_W'(REG_TIMING)) begin
      rdata_d = {{(BUS_DW - $bits(timing_t)){1'b0}}, timing_q};
    end else if (bus_addr == ADDR_W'(REG_DATA)) begin
      rdata_d = data_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      key_q    <= '0;
      reload_q <= 1'b0;
      err_q    <= 1'b0;
      timing_q <= RST_TIMING;
    end else begin
      addr_q   <= addr_d;
      key_q    <= key_d;
      reload_q <= reload_d;
      err_q    <= err_d;
      timing_q <= timing_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (start_prog_o) begin
      data_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_ready <= 1'b0;
    end else begin
      bus_rdata <= rdata_d;
      bus_ready <= bus_wr;
    end
  end

  assign word_idx_o  = addr_q[IDX_W-1:0];
  assign prog_data_o = data_q;
  assign timing_o    = timing_q;

  // R10
  busy_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i && (hit_ctrl || hit_set) |=> $stable(addr_q));

  // R6
  key_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done_i |=> key_q == 16'd0);

  // R8
  reload_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reload_q) |-> $past(load_done_i));

  // R7
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_data && busy_i |=> err_q);
endmodule

// File: rtl/otp_shadow_ctrl.sv
module otp_shadow_ctrl
  import otp_pkg::*;
#(
  parameter int unsigned NW     = 128,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_wr,
  output logic [31:0]       bus_rdata,
  output logic              bus_ready
);
  localparam int unsigned IDX_W = $clog2(NW);
  localparam timing_t RST_TIMING = '{rd_len: 6'd1, relax: 4'd1, pgm_len: 12'd9};

  logic [1:0]        rst_sync_q;
  logic              core_rst_n;
  logic              busy, pgm_fire, prog_done, load_done, shadow_we;
  logic              start_prog, start_load;
  logic [IDX_W-1:0]  load_idx, word_idx, rd_idx;
  logic [BUS_DW-1:0] prog_data, shadow_word;
  timing_t           timing;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign core_rst_n = rst_sync_q[1];

  otp_regs #(.NW(NW), .ADDR_W(ADDR_W), .RST_TIMING(RST_TIMING)) regs_i (
    .clk          (clk),
    .rst_n        (core_rst_n),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_wr       (bus_wr),
    .bus_rdata    (bus_rdata),
    .bus_ready    (bus_ready),
    .busy_i       (busy),
    .prog_done_i  (prog_done),
    .load_done_i  (load_done),
    .shadow_word_i(shadow_word),
    .shadow_idx_o (rd_idx),
    .start_prog_o (start_prog),
    .start_load_o (start_load),
    .word_idx_o   (word_idx),
    .prog_data_o  (prog_data),
    .timing_o     (timing)
  );

  otp_seq #(.NW(NW)) seq_i (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .start_load_i(start_load),
    .start_prog_i(start_prog),
    .timing_i    (timing),
    .busy_o      (busy),
    .pgm_fire_o  (pgm_fire),
    .prog_done_o (prog_done),
    .load_done_o (load_done),
    .shadow_we_o (shadow_we),
    .load_idx_o  (load_idx)
  );

  otp_fuse_store #(.NW(NW)) store_i (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .pgm_fire_i (pgm_fire),
    .pgm_idx_i  (word_idx),
    .pgm_data_i (prog_data),
    .shadow_we_i(shadow_we),
    .load_idx_i (load_idx),
    .rd_idx_i   (rd_idx),
    .rd_word_o  (shadow_word)
  );

  // R4
  fire_busy_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    pgm_fire |=> busy);
endmodule

// File: tb/otp_shadow_ctrl_tb_top.sv
module otp_shadow_ctrl_tb_top;
  logic        clk;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_wr;
  logic [31:0] bus_rdata;
  logic        bus_ready;

  int unsigned n_run;
  int unsigned n_fail;
  logic        last_ready;

  localparam logic [31:0] KEYW   = 32'h3E77_0000;
  localparam logic [31:0] TIM_TB = 32'h0001_2005;
  localparam int unsigned PGM_CYC  = 2 * (2 + 1) + (5 + 1);
  localparam int unsigned LOAD_CYC = 128 * (1 + 1);

  otp_shadow_ctrl dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_wr   (bus_wr),
    .bus_rdata(bus_rdata),
    .bus_ready(bus_ready)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr     = 1'b0;
    last_ready = bus_ready;
    bus_addr   = 12'h000;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    bus_wr   = 1'b0;
    @(posedge clk);
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic measure_busy(output int unsigned n);
    n = 0;
    bus_addr = 12'h000;
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (bus_rdata[8]) n++;
      else break;
    end
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 100000; i++) begin
      rd(12'h000, v);
      if (!v[8]) break;
    end
  endtask

  task automatic do_reload();
    wr(12'h004, 32'h0000_0400);
    wait_idle();
  endtask

  task automatic t_reset();
    logic [31:0] v;
    int unsigned n;
    rst_n = 1'b0;
    bus_addr = '0; bus_wdata = '0; bus_wr = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (bus_rdata[8]) break;
    end
    n = 1;
    measure_busy(n);
    n = n + 1;
    check(n >= LOAD_CYC && n <= LOAD_CYC + 1, "R1 boot busy cycles", n, LOAD_CYC);
    rd(12'h000, v);
    check(v == 32'h0, "R1 ctrl after boot", v, 32'h0);
    rd(12'h010, v);
    check(v == 32'h0001_1009, "R1 R3 timing reset", v, 32'h0001_1009);
  endtask

  task automatic t_timing();
    logic [31:0] v;
    wr(12'h010, TIM_TB);
    rd(12'h010, v);
    check(v == TIM_TB, "R3 timing readback", v, TIM_TB);
  endtask

  task automatic t_program();
    logic [31:0] v;
    int unsigned n;
    wr(12'h000, KEYW | 32'd5);
    rd(12'h000, v);
    check(v == (KEYW | 32'd5), "R2 ctrl write", v, KEYW | 32'd5);
    wr(12'h020, 32'h0000_00F0);
    check(last_ready == 1'b1, "R11 ready after write", {31'd0, last_ready}, 32'd1);
    measure_busy(n);
    check(n == PGM_CYC, "R4 program busy cycles", n, PGM_CYC);
    rd(12'h000, v);
    check(v == 32'd5, "R6 key cleared addr kept", v, 32'd5);
    rd(12'h400 + 12'd80, v);
    check(v == 32'h0, "R8 shadow unchanged before reload", v, 32'h0);
    wr(12'h004, 32'h0000_0400);
    rd(12'h000, v);
    check(v[10] && v[8], "R8 reload bit set while busy", v, 32'h0000_0505);
    wait_idle();
    rd(12'h000, v);
    check(v[10] == 1'b0, "R8 reload bit self clears", v, 32'd5);
    rd(12'h400 + 12'd80, v);
    check(v == 32'h0000_00F0, "R8 R9 shadow after reload", v, 32'h0000_00F0);
  endtask

  task automatic t_or();
    logic [31:0] v;
    int unsigned n;
    wr(12'h000, KEYW | 32'd5);
    wr(12'h020, 32'h0F00_000F);
    wait_idle();
    wr(12'h004, 32'h0000_0400);
    measure_busy(n);
    check(n == LOAD_CYC, "R8 reload busy cycles", n, LOAD_CYC);
    rd(12'h400 + 12'd80, v);
    check(v == 32'h0F00_00FF, "R5 OR programming", v, 32'h0F00_00FF);
  endtask

  task automatic t_badkey();
    logic [31:0] v;
    wr(12'h000, 32'h1234_0000 | 32'd7);
    wr(12'h020, 32'hFFFF_FFFF);
    rd(12'h000, v);
    check(v[9] && !v[8], "R7 error on bad key, not busy", v, 32'h1234_0207);
    do_reload();
    rd(12'h400 + 12'd112, v);
    check(v == 32'h0, "R7 bad key burns nothing", v, 32'h0);
    wr(12'h008, 32'h0000_0200);
    rd(12'h000, v);
    check(v[9] == 1'b0, "R7 error cleared", v, 32'h1234_0007);
  endtask

  task automatic t_busy();
    logic [31:0] v;
    wr(12'h000, KEYW | 32'h0000_0400 | 32'd9);
    wr(12'h000, 32'd3);
    wr(12'h020, 32'hAAAA_AAAA);
    wr(12'h010, 32'h0000_0000);
    wr(12'h004, 32'h0000_0010);
    wait_idle();
    rd(12'h000, v);
    check(v == (KEYW | 32'h0000_0200 | 32'd9), "R10 R7 ctrl after busy writes", v,
          KEYW | 32'h0000_0200 | 32'd9);
    rd(12'h010, v);
    check(v == TIM_TB, "R10 timing kept while busy", v, TIM_TB);
    do_reload();
    rd(12'h400 + 12'd144, v);
    check(v == 32'h0, "R7 busy data write burns nothing", v, 32'h0);
    wr(12'h008, 32'h0000_0200);
  endtask

  task automatic t_edges();
    logic [31:0] v;
    wr(12'h000, KEYW);
    wr(12'h020, 32'h1357_9BDF);
    wait_idle();
    wr(12'h000, KEYW | 32'd127);
    wr(12'h020, 32'h8000_0001);
    wait_idle();
    do_reload();
    rd(12'h400, v);
    check(v == 32'h1357_9BDF, "R9 shadow word 0", v, 32'h1357_9BDF);
    rd(12'hBF0, v);
    check(v == 32'h8000_0001, "R9 shadow word 127", v, 32'h8000_0001);
    rd(12'h404, v);
    check(v == 32'h0, "R9 unaligned reads zero", v, 32'h0);
    rd(12'hC00, v);
    check(v == 32'h0, "R9 past window reads zero", v, 32'h0);
    @(negedge clk);
    bus_addr = 12'h400;
    @(posedge clk);
    @(negedge clk);
    bus_addr = 12'hBF0;
    check(bus_rdata == 32'h1357_9BDF, "R11 read latency one cycle", bus_rdata, 32'h1357_9BDF);
  endtask

  task automatic t_setalias();
    logic [31:0] v;
    wr(12'h000, 32'h3E00_0001);
    wr(12'h004, 32'h0077_0002);
    rd(12'h000, v);
    check(v == 32'h3E77_0003, "R2 set alias ORs fields", v, 32'h3E77_0003);
  endtask

  initial begin
    n_run = 0;
    n_fail = 0;
    last_ready = 1'b0;
    t_reset();
    t_timing();
    t_program();
    t_or();
    t_badkey();
    t_busy();
    t_edges();
    t_setalias();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %h expected %h", 32'd150000, 32'd0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule